// File: doc/BRIEF.md
# Seconds Counter with Equality Alarm

This peripheral keeps a 32-bit count of seconds and raises an interrupt when that count reaches a programmed value. A one-cycle pulse on `tick_1hz`, made by a prescaler outside the block, advances the count by one. Software reaches the block through a 32-bit register bus that uses a setup phase followed by an access phase. Through it software can reload the count, set the alarm value, gate the interrupt and acknowledge it. Both the count and the comparison wrap modulo 2^32.

A small phase tracker follows the bus transfer. Its states are `PH_IDLE` (no transfer), `PH_ARMED` (a setup phase was seen in the last cycle, so this cycle may be the access phase) and `PH_DONE` (the access phase has completed). The transitions are: PH_IDLE to PH_ARMED on select without enable; PH_ARMED to PH_DONE on select with enable; PH_ARMED or PH_DONE back to PH_ARMED on a new select without enable; anything else returns to PH_IDLE. A register write is performed only in an access-phase cycle while the tracker is in PH_ARMED, so each transfer writes exactly once.

Register map, by word offset: 0x00 current count, 0x04 alarm value, 0x08 load, 0x0C control, 0x10 interrupt gate, 0x14 raw status, 0x18 gated status, 0x1C acknowledge. Offsets 0xFE0 to 0xFFC hold identification bytes.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the count, alarm value, load readback, gate bit and raw status all read 0, and `irq` is 0.
- R2: A write to 0x08 sets the count to the written value. Counting continues from that value, and 0x08 reads back the value last written.
- R3: The count increases by one at the clock edge where `tick_1hz` is high. A load write in the same cycle wins over the increment.
- R4: Raw status (bit 0 of 0x14) becomes 1 when the count reaches the alarm value (0x04), and this includes a match reached after the count wraps from 0xFFFFFFFF to 0.
- R5: A write to 0x08 or 0x04 that leaves count equal to alarm sets raw status at the same edge, with no tick needed. Without such a write, raw status is set only on the cycle equality first becomes true, so an acknowledge is not undone while the count stays equal.
- R6: Only bit 0 of 0x10 is stored and it reads back zero-extended. 0x18 reads raw AND gate, and `irq` carries the same value.
- R7: Any write to 0x1C clears raw status, whatever the data. If an alarm event occurs in the same cycle, the set wins.
- R8: 0x0C always reads 1, and writes to it have no effect.
- R9: Reads of 0xFE0, 0xFE4 … 0xFFC return, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Writes to 0x00, 0x14 and 0x18 change nothing, and 0x1C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access-phase enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, raw status AND gate |

## Verification
The checker checks the following every cycle:
- the count steps by exactly one on a tick, takes the loaded value on a load write, and otherwise holds;
- raw status rises only when count equals alarm;
- raw status falls only after an acknowledge write;
- `irq` never rises without raw status;
- the control word always reads 1.

The bench scenarios cover the rest:
- identification bytes;
- that the gate keeps only one bit;
- an alarm reached across the 32-bit wrap;
- the immediate alarm on a load or alarm write;
- no re-fire while the count stays equal;
- that writes to the read-only words have no effect.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_DONE  = 2'd2
    } bus_phase_e;

    // word index (byte address bits [11:2]) of each register
    localparam logic [9:0] W_COUNT  = 10'h000;
    localparam logic [9:0] W_ALARM  = 10'h001;
    localparam logic [9:0] W_LOAD   = 10'h002;
    localparam logic [9:0] W_CTRL   = 10'h003;
    localparam logic [9:0] W_GATE   = 10'h004;
    localparam logic [9:0] W_RAW    = 10'h005;
    localparam logic [9:0] W_GATED  = 10'h006;
    localparam logic [9:0] W_ACK    = 10'h007;
    localparam logic [6:0] ID_BLOCK = 7'h7F;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_sel,
    input  logic bus_en,
    input  logic bus_wr,
    output logic wr_stb
);
    bus_phase_e state_q, state_n;

    always_comb begin
        state_n = PH_IDLE;
        unique case (state_q)
            PH_IDLE:  state_n = (bus_sel && !bus_en) ? PH_ARMED : PH_IDLE;
            PH_ARMED: begin
                if (bus_sel && bus_en)       state_n = PH_DONE;
                else if (bus_sel && !bus_en) state_n = PH_ARMED;
                else                         state_n = PH_IDLE;
            end
            PH_DONE:  state_n = (bus_sel && !bus_en) ? PH_ARMED : PH_IDLE;
            default:  state_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            PH_ARMED: wr_stb = bus_sel && bus_en && bus_wr;
            PH_IDLE, PH_DONE: wr_stb = 1'b0;
            default:  wr_stb = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] alarm_q,
    output logic [CNT_W-1:0] loaded_q,
    output logic             hit
);
    logic [CNT_W-1:0] count_n, alarm_n;
    logic             eq_n, eq_q;

    always_comb begin
        if (load_wr)   count_n = wdata;
        else if (tick) count_n = count_q + CNT_W'(1);
        else           count_n = count_q;
        alarm_n = alarm_wr ? wdata : alarm_q;
        eq_n    = (count_n == alarm_n);
        hit     = eq_n && (!eq_q || load_wr || alarm_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            alarm_q  <= '0;
            loaded_q <= '0;
            eq_q     <= 1'b1;
        end else begin
            count_q  <= count_n;
            alarm_q  <= alarm_n;
            eq_q     <= eq_n;
            if (load_wr) loaded_q <= wdata;
        end
    end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack_wr,
    input  logic gate_wr,
    input  logic gate_bit,
    output logic raw_q,
    output logic gate_q,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            if (hit)         raw_q <= 1'b1;
            else if (ack_wr) raw_q <= 1'b0;
            if (gate_wr) gate_q <= gate_bit;
        end
    end

    assign irq = raw_q & gate_q;
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;

    logic              wr_stb, load_wr, alarm_wr, gate_wr, ack_wr, hit;
    logic [DATA_W-1:0] count_q, alarm_q, loaded_q;
    logic              raw_q, gate_q;
    logic [WORD_W-1:0] word;

    assign word     = bus_addr[ADDR_W-1:2];
    assign load_wr  = wr_stb && (word == W_LOAD);
    assign alarm_wr = wr_stb && (word == W_ALARM);
    assign gate_wr  = wr_stb && (word == W_GATE);
    assign ack_wr   = wr_stb && (word == W_ACK);

    rtc_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
        .bus_wr(bus_wr), .wr_stb(wr_stb)
    );

    rtc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load_wr(load_wr),
        .alarm_wr(alarm_wr), .wdata(bus_wdata), .count_q(count_q),
        .alarm_q(alarm_q), .loaded_q(loaded_q), .hit(hit)
    );

    rtc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack_wr(ack_wr),
        .gate_wr(gate_wr), .gate_bit(bus_wdata[0]), .raw_q(raw_q),
        .gate_q(gate_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1:5] == ID_BLOCK) begin
            bus_rdata = DATA_W'(id_byte(bus_addr[4:2]));
        end else begin
            unique case (word)
                W_COUNT: bus_rdata = count_q;
                W_ALARM: bus_rdata = alarm_q;
                W_LOAD:  bus_rdata = loaded_q;
                W_CTRL:  bus_rdata = DATA_W'(1);
                W_GATE:  bus_rdata = DATA_W'(gate_q);
                W_RAW:   bus_rdata = DATA_W'(raw_q);
                W_GATED: bus_rdata = DATA_W'(raw_q & gate_q);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              load_wr,
    input logic              ack_wr,
    input logic              bus_sel,
    input logic [11:0]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic              raw_q,
    input logic              irq
);
    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !load_wr) |=> (count_q == $past(count_q) + DATA_W'(1)));
    assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count_q == $past(bus_wdata)));
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !load_wr) |=> $stable(count_q));
    assert_raw_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> (count_q == alarm_q));
    assert_raw_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_q) |-> $past(ack_wr));
    assert_irq_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_q);
    assert_ctrl_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == 12'h00C) |-> (bus_rdata == DATA_W'(1)));
endmodule

bind rtc_alarm_top rtc_alarm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .load_wr(load_wr),
    .ack_wr(ack_wr), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_q(count_q),
    .alarm_q(alarm_q), .raw_q(raw_q), .irq(irq)
);

// File: tb/rtc_alarm_top_bench.sv
module rtc_alarm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    rtc_alarm_top u_rtc_alarm_top (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares each read access phase against the queue
    always @(negedge clk) begin
        if (bus_sel && bus_en && !bus_wr && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (bus_rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: addr %h got %h expected %h", e.tag, bus_addr, bus_rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1 bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_en = 1;
        @(posedge clk); #1 bus_sel = 0; bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1 bus_sel = 1; bus_en = 0; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1 bus_en = 1;
        @(posedge clk); #1 bus_sel = 0; bus_en = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1 tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] ids [8];
        ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(12'h000, 0, "R1 count"); rd(12'h004, 0, "R1 alarm");
        rd(12'h008, 0, "R1 load"); rd(12'h010, 0, "R1 gate");
        rd(12'h014, 0, "R1 raw"); chk_irq(0, "R1 irq");
        // R8 control
        rd(12'h00C, 1, "R8 ctrl"); wr(12'h00C, 0); rd(12'h00C, 1, "R8 ctrl after write");
        // R2 load
        wr(12'h008, 100); rd(12'h000, 100, "R2 count"); rd(12'h008, 100, "R2 load readback");
        // R3 ticks
        tick(); tick(); tick(); rd(12'h000, 103, "R3 count after 3 ticks");
        // R4/R6 match and gate
        wr(12'h004, 105); wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, 1, "R6 gate one bit");
        tick(); rd(12'h014, 0, "R4 raw before match");
        tick(); rd(12'h014, 1, "R4 raw at match"); rd(12'h018, 1, "R6 gated");
        chk_irq(1, "R6 irq");
        // R7 clear with zero data, R5 no re-fire while equal
        wr(12'h01C, 0); rd(12'h014, 0, "R7 raw cleared"); chk_irq(0, "R7 irq");
        repeat (4) @(posedge clk); rd(12'h014, 0, "R5 no refire");
        // R5 immediate on alarm write
        wr(12'h004, 105); rd(12'h014, 1, "R5 alarm write immediate");
        wr(12'h01C, 32'hDEAD_0000); rd(12'h014, 0, "R7 clear any data");
        // R5 immediate on load write
        wr(12'h004, 300); wr(12'h008, 300); rd(12'h014, 1, "R5 load write immediate");
        wr(12'h01C, 1);
        // R4 wrap
        wr(12'h004, 1); wr(12'h008, 32'hFFFF_FFFE);
        tick(); rd(12'h014, 0, "R4 no raw at FFFFFFFF");
        tick(); rd(12'h000, 0, "R4 wrapped count"); rd(12'h014, 0, "R4 no raw at 0");
        tick(); rd(12'h014, 1, "R4 raw after wrap");
        // R6 gate off
        wr(12'h010, 32'hFFFF_FFFE); rd(12'h010, 0, "R6 gate bit0 only");
        rd(12'h018, 0, "R6 gated off"); chk_irq(0, "R6 irq gated off");
        // R10 ignored writes
        wr(12'h014, 0); rd(12'h014, 1, "R10 raw write ignored");
        wr(12'h018, 0); rd(12'h014, 1, "R10 gated write ignored");
        wr(12'h000, 77); rd(12'h000, 1, "R10 count write ignored");
        rd(12'h01C, 0, "R10 ack reads 0");
        // R3 load beats tick in same cycle
        @(posedge clk); #1 bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = 12'h008; bus_wdata = 50;
        @(posedge clk); #1 bus_en = 1; tick_1hz = 1;
        @(posedge clk); #1 bus_sel = 0; bus_en = 0; bus_wr = 0; tick_1hz = 0;
        rd(12'h000, 50, "R3 load priority");
        // R9 ID bytes
        for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4), {24'h0, ids[i]}, "R9 id byte");
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule